// File: doc/BRIEF.md
# Byte-Wide Host Port to 16-Bit Memory Bridge

This block lets an 8-bit host reach a 16-bit internal address space through a handful of byte registers. The host sees a 4-bit register offset, a bidirectional byte bus, and three active-low strobes: select, write and output-enable. On the internal side the bridge drives a simple synchronous memory bus. A host transfer goes like this. The host loads a byte count and a start address. For a write it fills a staging buffer through a data window. It then writes a command code. The bridge moves the bytes one after another, advancing the address and counting the remaining bytes down to zero. When the burst is over it clears the command register and raises a ready cause. A rejected command raises an error cause. An interrupt output is high while any cause is set whose mask bit is clear.

Host strobes are sampled on the block clock. A write takes effect on the first clock that sees select and write-enable low together. A read drives the byte bus while select and output-enable are low and write-enable is high. Side effects of a read (pointer advance, cause clear) happen on the clock after the read strobe is released.

The transfer engine is a five-state machine:
- ST_IDLE waits for an accepted command. It goes to ST_FINISH when the count is zero, to ST_PUT for code 0x01, and to ST_GET_REQ for code 0x02.
- ST_PUT writes one byte per cycle. It stays in ST_PUT until the last byte, then goes to ST_FINISH.
- ST_GET_REQ issues a memory read and always goes on to ST_GET_CAP.
- ST_GET_CAP stores the returned byte. It goes back to ST_GET_REQ, or to ST_FINISH after the last byte.
- ST_FINISH clears the command, sets the ready cause and returns to ST_IDLE.

Top module: `hpb_host_bridge`

## Requirements
- R1: After reset, every readable register reads 0x00: command, count, address low and high, cause and mask. The interrupt output is low and no memory request is made.
- R2: Offsets 0x1 (count), 0x2 (address bits 7:0) and 0x3 (address bits 15:8) read back what was written. The mask at offset 0x9 keeps only bits 3 and 2, so writing 0xFF reads back 0x0C. Unused offsets such as 0x5 read 0x00.
- R3: Offset 0x4 is a data window on a staging buffer with one shared byte pointer. Each host write or completed read of the window advances the pointer by one. A count write, an accepted command, or the end of a transfer sets the pointer back to zero.
- R4: Command code 0x01 with count N copies buffer bytes 0 to N-1 to internal addresses A to A+N-1. It makes exactly N memory write requests on consecutive cycles.
- R5: Command code 0x02 with count N makes exactly N memory reads, one every two cycles. It fills buffer bytes 0 to N-1 from A to A+N-1, and the host then reads them in order through offset 0x4.
- R6: While a transfer runs, the command register reads back its code. It returns to 0x00 when the transfer ends. Afterwards the count reads 0 and the address reads A+N.
- R7: A command with count 0 finishes without any memory request and sets the ready cause.
- R8: While busy, a command write is ignored and sets the error cause, and the running transfer completes unchanged. Writes to count, address and data are also ignored while busy.
- R9: While idle, a nonzero code other than 0x01 or 0x02 starts nothing, leaves the command at 0x00 and sets the error cause. Writing 0x00 to the command register has no effect.
- R10: The cause register at offset 0x8 has ready at bit 2 and error at bit 3. It reads the same whatever the mask holds, and it clears when a host read of offset 0x8 ends.
- R11: The interrupt output is high exactly when a cause bit is set whose mask bit at offset 0x9 is 0. Ready is masked by bit 2 and error by bit 3.
- R12: The internal address wraps from 0xFFFF to 0x0000 within a burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 4 | Host register offset |
| host_data | inout | 8 | Host byte bus |
| host_cs_n | input | 1 | Host select, active low |
| host_we_n | input | 1 | Host write strobe, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_irq | output | 1 | Interrupt request, active high |
| mem_req | output | 1 | Internal memory access request |
| mem_we | output | 1 | Internal access is a write |
| mem_addr | output | 16 | Internal byte address |
| mem_wdata | output | 8 | Internal write byte |
| mem_rdata | input | 8 | Internal read byte, valid the cycle after a read request |

## Verification
On every cycle, the assertions check the following. Memory requests occur only while the command register is busy. The command register clears only after the engine's finish state. Each engine step advances the address by one with wrap-around and lowers the count by one. No step happens at count zero. A finish always leaves the ready cause set, and the interrupt stays low with no cause pending. The bench scenarios cover what the assertions cannot. They confirm that the right bytes land at the right addresses over a sweep of burst lengths, and that read bursts return fresh memory contents in order. They also show that commands and register writes issued during a burst are rejected without disturbing it. Finally, they sweep every mask and cause combination against the interrupt output and confirm clear-on-read.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 4;

    localparam logic [OFS_W-1:0] OFS_CMD     = 4'h0;
    localparam logic [OFS_W-1:0] OFS_CNT     = 4'h1;
    localparam logic [OFS_W-1:0] OFS_ADDR_LO = 4'h2;
    localparam logic [OFS_W-1:0] OFS_ADDR_HI = 4'h3;
    localparam logic [OFS_W-1:0] OFS_DATA    = 4'h4;
    localparam logic [OFS_W-1:0] OFS_CAUSE   = 4'h8;
    localparam logic [OFS_W-1:0] OFS_MASK    = 4'h9;

    localparam logic [BYTE_W-1:0] CODE_PUT = 8'h01;
    localparam logic [BYTE_W-1:0] CODE_GET = 8'h02;

    localparam int BIT_READY = 2;
    localparam int BIT_ERROR = 3;
    localparam int NUM_SRC   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUT,
        ST_GET_REQ,
        ST_GET_CAP,
        ST_FINISH
    } eng_state_t;

endpackage

// File: rtl/hpb_buffer.sv
module hpb_buffer #(
    parameter int IDX_W = 8
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          idx,
    input  logic [hpb_pkg::BYTE_W-1:0] wr_byte,
    output logic [hpb_pkg::BYTE_W-1:0] rd_byte
);
    localparam int DEPTH = 1 << IDX_W;

    logic [hpb_pkg::BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[idx] <= wr_byte;
        end
    end

    assign rd_byte = cells[idx];
endmodule

// File: rtl/hpb_irq.sv
module hpb_irq (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       set_ready,
    input  logic                       set_error,
    input  logic                       clear,
    input  logic                       mask_wr,
    input  logic [hpb_pkg::BYTE_W-1:0] mask_in,
    output logic [hpb_pkg::BYTE_W-1:0] cause_byte,
    output logic [hpb_pkg::BYTE_W-1:0] mask_byte,
    output logic                       irq
);
    import hpb_pkg::*;

    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] cause_q;
    logic [NUM_SRC-1:0] mask_q;

    assign set_vec = {set_error, set_ready};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int POS = BIT_READY + i;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cause_q[i] <= 1'b0;
                mask_q[i]  <= 1'b0;
            end else begin
                cause_q[i] <= (cause_q[i] && !clear) || set_vec[i];
                if (mask_wr) begin
                    mask_q[i] <= mask_in[POS];
                end
            end
        end
    end

    always_comb begin
        cause_byte = '0;
        mask_byte  = '0;
        cause_byte[BIT_ERROR:BIT_READY] = cause_q;
        mask_byte[BIT_ERROR:BIT_READY]  = mask_q;
    end

    assign irq = |(cause_q & ~mask_q);
endmodule

// File: rtl/hpb_regs.sv
module hpb_regs #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [hpb_pkg::OFS_W-1:0]  h_addr,
    input  logic [hpb_pkg::BYTE_W-1:0] h_wbyte,
    input  logic                       h_cs_n,
    input  logic                       h_we_n,
    input  logic                       h_oe_n,
    output logic                       h_drive,
    output logic [hpb_pkg::BYTE_W-1:0] h_rbyte,
    input  logic [hpb_pkg::BYTE_W-1:0] cause_byte,
    input  logic [hpb_pkg::BYTE_W-1:0] mask_byte,
    output logic                       mask_wr,
    output logic                       cause_clr,
    output logic                       cmd_err,
    output logic                       start,
    output logic                       start_get,
    input  logic                       step,
    input  logic                       done,
    input  logic                       cap_en,
    input  logic [hpb_pkg::BYTE_W-1:0] cap_byte,
    output logic [CW-1:0]              count_q,
    output logic [AW-1:0]              addr_q,
    output logic                       busy,
    output logic [hpb_pkg::BYTE_W-1:0] buf_byte
);
    import hpb_pkg::*;

    logic                  wr_act, wr_act_q, rd_act, rd_act_q;
    logic                  wr_pulse, rd_end;
    logic [OFS_W-1:0]      rd_ofs_q;
    logic [BYTE_W-1:0]     cmd_q;
    logic [CW-1:0]         ptr_q;
    logic                  wr_cmd, code_ok, host_buf_wr, host_buf_adv, cnt_wr;
    logic                  buf_we;
    logic [BYTE_W-1:0]     buf_wbyte;

    assign wr_act   = !h_cs_n && !h_we_n;
    assign rd_act   = !h_cs_n && !h_oe_n && h_we_n;
    assign wr_pulse = wr_act && !wr_act_q;
    assign rd_end   = rd_act_q && !rd_act;
    assign busy     = (cmd_q != '0);

    assign wr_cmd       = wr_pulse && (h_addr == OFS_CMD);
    assign code_ok      = (h_wbyte == CODE_PUT) || (h_wbyte == CODE_GET);
    assign start        = wr_cmd && !busy && code_ok;
    assign start_get    = (h_wbyte == CODE_GET);
    assign cmd_err      = wr_cmd && (busy || ((h_wbyte != '0) && !code_ok));
    assign mask_wr      = wr_pulse && (h_addr == OFS_MASK);
    assign cause_clr    = rd_end && (rd_ofs_q == OFS_CAUSE);
    assign cnt_wr       = wr_pulse && (h_addr == OFS_CNT) && !busy;
    assign host_buf_wr  = wr_pulse && (h_addr == OFS_DATA) && !busy;
    assign host_buf_adv = host_buf_wr || (rd_end && (rd_ofs_q == OFS_DATA) && !busy);

    assign buf_we    = host_buf_wr || cap_en;
    assign buf_wbyte = cap_en ? cap_byte : h_wbyte;

    hpb_buffer #(.IDX_W(CW)) u_buffer (
        .clk     (clk),
        .wr_en   (buf_we),
        .idx     (ptr_q),
        .wr_byte (buf_wbyte),
        .rd_byte (buf_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            rd_act_q <= 1'b0;
            rd_ofs_q <= '0;
        end else begin
            wr_act_q <= wr_act;
            rd_act_q <= rd_act;
            if (rd_act) begin
                rd_ofs_q <= h_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            count_q <= '0;
            addr_q  <= '0;
            ptr_q   <= '0;
        end else begin
            if (start) begin
                cmd_q <= h_wbyte;
            end else if (done) begin
                cmd_q <= '0;
            end

            if (cnt_wr) begin
                count_q <= h_wbyte[CW-1:0];
            end else if (step) begin
                count_q <= count_q - 1'b1;
            end

            if (wr_pulse && !busy && (h_addr == OFS_ADDR_LO)) begin
                addr_q[7:0] <= h_wbyte;
            end else if (wr_pulse && !busy && (h_addr == OFS_ADDR_HI)) begin
                addr_q[AW-1:8] <= h_wbyte[AW-9:0];
            end else if (step) begin
                addr_q <= addr_q + 1'b1;
            end

            if (cnt_wr || start || done) begin
                ptr_q <= '0;
            end else if (step || host_buf_adv) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    assign h_drive = rd_act;

    always_comb begin
        h_rbyte = '0;
        case (h_addr)
            OFS_CMD:     h_rbyte = cmd_q;
            OFS_CNT:     h_rbyte = BYTE_W'(count_q);
            OFS_ADDR_LO: h_rbyte = addr_q[7:0];
            OFS_ADDR_HI: h_rbyte = BYTE_W'(addr_q[AW-1:8]);
            OFS_DATA:    h_rbyte = buf_byte;
            OFS_CAUSE:   h_rbyte = cause_byte;
            OFS_MASK:    h_rbyte = mask_byte;
            default:     h_rbyte = '0;
        endcase
    end
endmodule

// File: rtl/hpb_engine.sv
module hpb_engine #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       start_get,
    input  logic [CW-1:0]              count_q,
    input  logic [AW-1:0]              addr_q,
    input  logic [hpb_pkg::BYTE_W-1:0] buf_byte,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [AW-1:0]              mem_addr,
    output logic [hpb_pkg::BYTE_W-1:0] mem_wdata,
    output logic                       step,
    output logic                       cap_en,
    output logic                       done
);
    import hpb_pkg::*;

    eng_state_t state_q, state_d;
    logic       last_byte;

    assign last_byte = (count_q == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (count_q == '0) begin
                        state_d = ST_FINISH;
                    end else if (start_get) begin
                        state_d = ST_GET_REQ;
                    end else begin
                        state_d = ST_PUT;
                    end
                end
            end
            ST_PUT:     state_d = last_byte ? ST_FINISH : ST_PUT;
            ST_GET_REQ: state_d = ST_GET_CAP;
            ST_GET_CAP: state_d = last_byte ? ST_FINISH : ST_GET_REQ;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        step    = 1'b0;
        cap_en  = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PUT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                step    = 1'b1;
            end
            ST_GET_REQ: mem_req = 1'b1;
            ST_GET_CAP: begin
                step   = 1'b1;
                cap_en = 1'b1;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = buf_byte;
endmodule

// File: rtl/hpb_host_bridge.sv
module hpb_host_bridge #(
    parameter int MEM_AW = 16,
    parameter int CNT_W  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  host_addr,
    inout  wire  [7:0]  host_data,
    input  logic        host_cs_n,
    input  logic        host_we_n,
    input  logic        host_oe_n,
    output logic        host_irq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata
);
    import hpb_pkg::*;

    logic              h_drive;
    logic [BYTE_W-1:0] h_rbyte;
    logic [BYTE_W-1:0] cause_byte, mask_byte, buf_byte;
    logic              mask_wr, cause_clr, cmd_err, start, start_get;
    logic              eng_step, eng_done, eng_cap;
    logic [CNT_W-1:0]  count_q;
    logic [MEM_AW-1:0] addr_q;
    logic [MEM_AW-1:0] eng_addr;
    logic              busy;

    assign host_data = h_drive ? h_rbyte : 8'bz;
    assign mem_addr  = 16'(eng_addr);

    hpb_regs #(.AW(MEM_AW), .CW(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_addr     (host_addr),
        .h_wbyte    (host_data),
        .h_cs_n     (host_cs_n),
        .h_we_n     (host_we_n),
        .h_oe_n     (host_oe_n),
        .h_drive    (h_drive),
        .h_rbyte    (h_rbyte),
        .cause_byte (cause_byte),
        .mask_byte  (mask_byte),
        .mask_wr    (mask_wr),
        .cause_clr  (cause_clr),
        .cmd_err    (cmd_err),
        .start      (start),
        .start_get  (start_get),
        .step       (eng_step),
        .done       (eng_done),
        .cap_en     (eng_cap),
        .cap_byte   (mem_rdata),
        .count_q    (count_q),
        .addr_q     (addr_q),
        .busy       (busy),
        .buf_byte   (buf_byte)
    );

    hpb_engine #(.AW(MEM_AW), .CW(CNT_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_get (start_get),
        .count_q   (count_q),
        .addr_q    (addr_q),
        .buf_byte  (buf_byte),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (eng_addr),
        .mem_wdata (mem_wdata),
        .step      (eng_step),
        .cap_en    (eng_cap),
        .done      (eng_done)
    );

    hpb_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_ready  (eng_done),
        .set_error  (cmd_err),
        .clear      (cause_clr),
        .mask_wr    (mask_wr),
        .mask_in    (host_data),
        .cause_byte (cause_byte),
        .mask_byte  (mask_byte),
        .irq        (host_irq)
    );
endmodule

// File: rtl/hpb_host_bridge_chk.sv
module hpb_host_bridge_chk #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          busy,
    input logic          done,
    input logic          step,
    input logic [CW-1:0] count_q,
    input logic [AW-1:0] addr_q,
    input logic [7:0]    cause_byte,
    input logic          host_irq
);
    p_access_only_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    p_self_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (count_q == CW'($past(count_q) - 1'b1)));

    p_no_step_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (count_q != '0));

    p_ready_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cause_byte[2]);

    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_byte == 8'h00) |-> !host_irq);

    p_addr_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (addr_q == AW'($past(addr_q) + 1'b1)));
endmodule

bind hpb_host_bridge hpb_host_bridge_chk #(.AW(MEM_AW), .CW(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .busy       (busy),
    .done       (eng_done),
    .step       (eng_step),
    .count_q    (count_q),
    .addr_q     (addr_q),
    .cause_byte (cause_byte),
    .host_irq   (host_irq)
);

// File: tb/hpb_host_bridge_bench.sv
module hpb_host_bridge_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  h_addr = '0;
    logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [7:0]  drv = '0;
    logic        drv_en = 1'b0;
    wire  [7:0]  host_data;
    logic        host_irq, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    logic [7:0]  ram [256];
    logic [7:0]  model [256];
    logic        pre_we = 1'b0;
    logic [7:0]  pre_idx = '0, pre_val = '0;
    int          req_total = 0;
    int          n_checks = 0, n_fail = 0;

    assign host_data = drv_en ? drv : 8'bz;

    always #(CLK_PERIOD/2) clk = ~clk;

    hpb_host_bridge u_hpb_host_bridge (
        .clk(clk), .rst_n(rst_n), .host_addr(h_addr), .host_data(host_data),
        .host_cs_n(cs_n), .host_we_n(we_n), .host_oe_n(oe_n), .host_irq(host_irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (pre_we) ram[pre_idx] <= pre_val;
        else if (mem_req && mem_we) ram[mem_addr[7:0]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= ram[mem_addr[7:0]];
        if (mem_req) req_total <= req_total + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        h_addr = a; drv = d; drv_en = 1'b1; cs_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1; drv_en = 1'b0;
    endtask

    task automatic hr(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        h_addr = a; cs_n = 1'b0; oe_n = 1'b0;
        #(CLK_PERIOD/4);
        d = host_data;
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic preload(input logic [7:0] idx, input logic [7:0] val);
        @(negedge clk);
        pre_idx = idx; pre_val = val; pre_we = 1'b1;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 2000; i++) begin
            hr(4'h0, v);
            if (v == 8'h00) break;
        end
    endtask

    task automatic set_xfer(input logic [7:0] n, input logic [15:0] a);
        hw(4'h1, n);
        hw(4'h2, a[7:0]);
        hw(4'h3, a[15:8]);
    endtask

    task automatic chk_addr(input string tag, input logic [15:0] exp);
        logic [7:0] lo, hi;
        hr(4'h2, lo);
        hr(4'h3, hi);
        chk(tag, {hi, lo}, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] a;
        int          snap;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", host_irq, 0);
        chk("R1 mem_req", mem_req, 0);
        for (int o = 0; o < 10; o++) begin
            hr(4'(o), v);
            chk("R1 register", v, 0);
        end

        // R2 register readback
        hw(4'h9, 8'hFF); hr(4'h9, v); chk("R2 mask", v, 8'h0C);
        hw(4'h9, 8'h00); hr(4'h9, v); chk("R2 mask clear", v, 0);
        set_xfer(8'h5A, 16'h1234);
        hr(4'h1, v); chk("R2 count", v, 8'h5A);
        chk_addr("R2 address", 16'h1234);
        hr(4'h5, v); chk("R2 unused", v, 0);

        // R4 R5 R6 sweep of burst lengths
        for (int n = 1; n <= 14; n++) begin
            int len;
            len = (n == 14) ? 40 : n;
            a = {8'(n), 8'(n * 13)};
            set_xfer(8'(len), a);
            for (int i = 0; i < len; i++) begin
                model[8'(a[7:0] + i)] = 8'((n * 7 + i * 3) ^ 8'h5A);
                hw(4'h4, model[8'(a[7:0] + i)]);
            end
            snap = req_total;
            hw(4'h0, 8'h01);
            if (len >= 4) begin
                hr(4'h0, v); chk("R6 busy code", v, 8'h01);
            end
            wait_idle();
            chk("R4 write requests", req_total - snap, len);
            for (int i = 0; i < len; i++)
                chk("R4 memory byte", ram[8'(a[7:0] + i)], model[8'(a[7:0] + i)]);
            chk_addr("R6 end address", 16'(a + 16'(len)));
            hr(4'h1, v); chk("R6 end count", v, 0);
            hr(4'h8, v); chk("R10 ready cause", v, 8'h04);

            for (int i = 0; i < len; i++) begin
                model[8'(a[7:0] + i)] = 8'(~(n * 5 + i * 11));
                preload(8'(a[7:0] + i), model[8'(a[7:0] + i)]);
            end
            set_xfer(8'(len), a);
            snap = req_total;
            hw(4'h0, 8'h02);
            wait_idle();
            chk("R5 read requests", req_total - snap, len);
            for (int i = 0; i < len; i++) begin
                hr(4'h4, v);
                chk("R5 R3 window byte", v, model[8'(a[7:0] + i)]);
            end
            hr(4'h8, v); chk("R10 ready after read", v, 8'h04);
        end

        // R3 pointer reset by count write
        hw(4'h1, 8'd3); hw(4'h4, 8'hAA); hw(4'h4, 8'hBB);
        set_xfer(8'd3, 16'h0070);
        hw(4'h4, 8'h11); hw(4'h4, 8'h22); hw(4'h4, 8'h33);
        hw(4'h0, 8'h01); wait_idle();
        chk("R3 byte0", ram[8'h70], 8'h11);
        chk("R3 byte1", ram[8'h71], 8'h22);
        chk("R3 byte2", ram[8'h72], 8'h33);
        hr(4'h8, v);

        // R7 zero count
        set_xfer(8'd0, 16'h0300);
        snap = req_total;
        hw(4'h0, 8'h01); wait_idle();
        chk("R7 no requests", req_total - snap, 0);
        hr(4'h8, v); chk("R7 ready", v, 8'h04);

        // R8 writes while busy
        set_xfer(8'd40, 16'h0880);
        for (int i = 0; i < 40; i++) begin
            model[8'(8'h80 + i)] = 8'(i * 9 + 1);
            hw(4'h4, model[8'(8'h80 + i)]);
        end
        snap = req_total;
        hw(4'h0, 8'h01);
        hw(4'h0, 8'h02);
        hw(4'h1, 8'h07);
        hw(4'h2, 8'hEE);
        hw(4'h4, 8'hC3);
        hr(4'h0, v); chk("R8 code kept", v, 8'h01);
        wait_idle();
        chk("R8 requests", req_total - snap, 40);
        for (int i = 0; i < 40; i++)
            chk("R8 memory byte", ram[8'(8'h80 + i)], model[8'(8'h80 + i)]);
        chk_addr("R8 address", 16'h08A8);
        hr(4'h1, v); chk("R8 count", v, 0);
        hr(4'h8, v); chk("R8 causes", v, 8'h0C);

        // R9 invalid and zero codes
        snap = req_total;
        hw(4'h0, 8'h7F);
        hr(4'h0, v); chk("R9 cmd stays idle", v, 0);
        chk("R9 no requests", req_total - snap, 0);
        hr(4'h8, v); chk("R9 error cause", v, 8'h08);
        hw(4'h0, 8'h00);
        hr(4'h8, v); chk("R9 zero code", v, 0);
        chk("R9 irq", host_irq, 0);

        // R10 R11 mask and cause sweep
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 4; c++) begin
                logic r, e;
                r = c[0]; e = c[1];
                hw(4'h9, 8'(m << 2));
                if (r) begin hw(4'h1, 8'd0); hw(4'h0, 8'h01); wait_idle(); end
                if (e) hw(4'h0, 8'h55);
                @(negedge clk);
                chk("R11 irq", host_irq, int'((r && !m[0]) || (e && !m[1])));
                hr(4'h8, v); chk("R10 cause under mask", v, c << 2);
                @(negedge clk);
                chk("R10 cleared irq", host_irq, 0);
                hr(4'h8, v); chk("R10 cleared", v, 0);
            end
        end
        hw(4'h9, 8'h00);

        // R12 wrap
        set_xfer(8'd4, 16'hFFFE);
        for (int i = 0; i < 4; i++) hw(4'h4, 8'(8'hD0 + i));
        hw(4'h0, 8'h01); wait_idle();
        chk_addr("R12 wrapped address", 16'h0002);
        chk("R12 byte FE", ram[8'hFE], 8'hD0);
        chk("R12 byte FF", ram[8'hFF], 8'hD1);
        chk("R12 byte 00", ram[8'h00], 8'hD2);
        chk("R12 byte 01", ram[8'h01], 8'hD3);
        hr(4'h8, v);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule